// File: doc/BRIEF.md
# Flash Line Buffer and Prefetch Controller

This block sits between one read port and a slow flash array. It holds a few line-sized buffers, each with a tag, a data line and a valid bit. A read that hits a valid buffer gets its data back one cycle after it is accepted. A read that misses fetches its line from the array. Reads are addressed by line, and `rd_instr` marks a read as an instruction fetch.

Three configuration inputs decide whether a line is kept and whether a prefetch starts:

- `cfg_buf_en` switches buffer hits on or off. While it is low, every valid bit is cleared.
- `cfg_ipf_en` lets instruction fetches start prefetches.
- `cfg_pf_mode` selects the prefetch limit.

In mode 00 instruction lines are never kept. In mode 01 an instruction miss keeps its line. In modes 10 and 11 an instruction hit also fetches the next line in the background, unless that line is already held. Data reads are kept whenever buffers are enabled, and they never start a prefetch. Integrating logic would normally drive mode 10 with both enables high out of reset.

The controller has five named states:

- IDLE: no array access in flight.
- DEMAND: waiting for a demand line.
- PREF: a background prefetch is in flight and reads are still accepted.
- JOIN: a demand miss is waiting on the prefetch of its own line.
- HOLD: a miss to a different line waits for the prefetch to finish, then issues its own fetch.

Transitions:

- IDLE to DEMAND on a miss.
- IDLE to PREF on a prefetching hit.
- PREF to IDLE on fill.
- PREF to JOIN on a same-line miss.
- PREF to HOLD on an other-line miss.
- JOIN to IDLE on fill.
- HOLD to DEMAND on fill.
- DEMAND to IDLE on fill.

The array side is a one-cycle request pulse followed, a fixed number of cycles later, by a one-cycle ready pulse that carries the data.

Top module: `fpb_ctrl`

## Requirements
- R1: A read that hits a valid buffer returns the held line with `rd_valid` high in the cycle after acceptance, and causes no array access.
- R2: A read that misses causes exactly one array access for its line and returns the array data, with `rd_valid` arriving later than one cycle after acceptance.
- R3: With `cfg_pf_mode`=00, instruction reads neither keep their line nor prefetch, so a repeated instruction read of the same line misses again.
- R4: With `cfg_pf_mode`=01, an instruction miss keeps its line, and an instruction hit starts no array access.
- R5: With `cfg_pf_mode`=1x, an instruction hit starts exactly one prefetch of line address+1 (wrapping) when that line is absent, and none when it is present. A miss never fetches the next line.
- R6: Data reads (`rd_instr`=0) keep their line whenever `cfg_buf_en`=1, in every mode, and never start a prefetch.
- R7: With `cfg_ipf_en`=0, instruction reads neither keep their line nor start a prefetch.
- R8: With `cfg_buf_en`=0, no read hits, nothing is kept or prefetched, and every line held before is a miss after buffers are re-enabled.
- R9: A fill goes into an empty buffer first. Otherwise it replaces the least recently used buffer, where both a hit and a fill count as a use.
- R10: While a prefetch is in flight, reads are accepted and hits are served in one cycle. A miss to the in-flight line waits for it and gets its data without a second array access.
- R11: A miss to another line during a prefetch waits until the prefetch ends, then issues its own array access.
- R12: At most one array access is outstanding at a time, and `arr_req` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_buf_en | input | 1 | Buffer enable; low clears all valid bits |
| cfg_ipf_en | input | 1 | Instruction fetches may prefetch |
| cfg_pf_mode | input | 2 | Prefetch limit: 00 off, 01 on miss, 1x miss and hit |
| rd_req | input | 1 | Read request |
| rd_addr | input | AW | Line address of the read |
| rd_instr | input | 1 | 1 = instruction fetch, 0 = data read |
| rd_ready | output | 1 | Read can be accepted this cycle |
| rd_valid | output | 1 | One-cycle pulse carrying read data |
| rd_data | output | DW | Read data line |
| arr_req | output | 1 | One-cycle array fetch request |
| arr_addr | output | AW | Line address of the array fetch |
| arr_ready | input | 1 | One-cycle pulse: array data is valid |
| arr_data | input | DW | Array data line |

## Verification
A wrong tag, valid bit or recency age shows up at the ports within one read. A line that should hit costs a full array round trip instead of one cycle, or a line that should miss returns in one cycle, possibly with stale data. A wrong prefetch decision shows up as an extra or missing array request in the few cycles after a hit. The bench measures the change in the request count per read to catch it. A state machine that mishandles an in-flight prefetch shows up either as a duplicated request for the same line or as a response whose data belongs to the wrong line.

// File: rtl/fpb_pkg.sv
package fpb_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_DEMAND,
        S_PREF,
        S_JOIN,
        S_HOLD
    } fpb_state_e;

    localparam logic [1:0] PFM_OFF  = 2'b00;
    localparam logic [1:0] PFM_MISS = 2'b01;
endpackage

// File: rtl/fpb_linebuf.sv
module fpb_linebuf #(
    parameter int NBUF = 4,
    parameter int AW   = 8,
    parameter int DW   = 32,
    localparam int IW  = $clog2(NBUF)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [AW-1:0] lk_addr,
    output logic          lk_hit,
    output logic [IW-1:0] lk_idx,
    output logic [DW-1:0] lk_data,
    input  logic [AW-1:0] nx_addr,
    output logic          nx_hit,
    input  logic          touch,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data
);
    logic [AW-1:0] tag_q  [NBUF];
    logic [DW-1:0] data_q [NBUF];
    logic [IW-1:0] age_q  [NBUF];
    logic [NBUF-1:0] vld_q;

    logic          wr_hit, inv_found, use_any;
    logic [IW-1:0] wr_hidx, inv_idx, old_idx, victim, use_idx;

    always_comb begin
        lk_hit    = 1'b0;
        lk_idx    = '0;
        nx_hit    = 1'b0;
        wr_hit    = 1'b0;
        wr_hidx   = '0;
        inv_found = 1'b0;
        inv_idx   = '0;
        old_idx   = '0;
        for (int i = 0; i < NBUF; i++) begin
            if (en && vld_q[i] && tag_q[i] == lk_addr) begin
                lk_hit = 1'b1;
                lk_idx = IW'(i);
            end
            if (en && vld_q[i] && tag_q[i] == nx_addr) nx_hit = 1'b1;
            if (vld_q[i] && tag_q[i] == wr_addr) begin
                wr_hit  = 1'b1;
                wr_hidx = IW'(i);
            end
            if (!vld_q[i] && !inv_found) begin
                inv_found = 1'b1;
                inv_idx   = IW'(i);
            end
            if (age_q[i] == IW'(NBUF - 1)) old_idx = IW'(i);
        end
        lk_data = data_q[lk_idx];
        victim  = wr_hit ? wr_hidx : (inv_found ? inv_idx : old_idx);
        use_any = (wr_en && en) || touch;
        use_idx = wr_en ? victim : lk_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < NBUF; i++) begin
                tag_q[i]  <= '0;
                data_q[i] <= '0;
                age_q[i]  <= IW'(i);
            end
        end else begin
            if (!en) begin
                vld_q <= '0;
            end else if (wr_en) begin
                vld_q[victim]  <= 1'b1;
                tag_q[victim]  <= wr_addr;
                data_q[victim] <= wr_data;
            end
            if (use_any) begin
                for (int i = 0; i < NBUF; i++) begin
                    if (IW'(i) == use_idx) age_q[i] <= '0;
                    else if (age_q[i] < age_q[use_idx]) age_q[i] <= age_q[i] + 1'b1;
                end
            end
        end
    end

    // R8
    valid_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (vld_q == '0));

    // R9
    use_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(touch && wr_en));
endmodule

// File: rtl/fpb_seq.sv
module fpb_seq
    import fpb_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_buf_en,
    input  logic          cfg_ipf_en,
    input  logic [1:0]    cfg_pf_mode,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    input  logic          rd_instr,
    output logic          rd_ready,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    input  logic          lk_hit,
    input  logic [DW-1:0] lk_data,
    input  logic          nx_hit,
    output logic          touch,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          arr_req,
    output logic [AW-1:0] arr_addr,
    input  logic          arr_ready,
    input  logic [DW-1:0] arr_data
);
    fpb_state_e state_q, state_d;

    logic [AW-1:0] fl_addr_q, fl_addr_d, hold_addr_q, hold_addr_d, iss_addr;
    logic          dem_fill_q, dem_fill_d, hold_fill_q, hold_fill_d;
    logic          rv_q, rv_d, areq_q, iss;
    logic [DW-1:0] rdat_q, rdat_d;
    logic [AW-1:0] aaddr_q;
    logic          accept, fill_ok, pf_ok;

    assign rd_ready = (state_q == S_IDLE) || (state_q == S_PREF && !arr_ready);
    assign accept   = rd_req && rd_ready;
    assign fill_ok  = cfg_buf_en && (!rd_instr || (cfg_ipf_en && cfg_pf_mode != PFM_OFF));
    assign pf_ok    = rd_instr && cfg_ipf_en && cfg_buf_en && cfg_pf_mode[1] && !nx_hit;

    assign rd_valid = rv_q;
    assign rd_data  = rdat_q;
    assign arr_req  = areq_q;
    assign arr_addr = aaddr_q;
    assign wr_addr  = fl_addr_q;
    assign wr_data  = arr_data;

    always_comb begin
        state_d     = state_q;
        fl_addr_d   = fl_addr_q;
        hold_addr_d = hold_addr_q;
        dem_fill_d  = dem_fill_q;
        hold_fill_d = hold_fill_q;
        iss         = 1'b0;
        iss_addr    = fl_addr_q;
        rv_d        = 1'b0;
        rdat_d      = rdat_q;
        touch       = 1'b0;
        wr_en       = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (accept) begin
                    if (lk_hit) begin
                        rv_d   = 1'b1;
                        rdat_d = lk_data;
                        touch  = 1'b1;
                        if (pf_ok) begin
                            iss       = 1'b1;
                            iss_addr  = rd_addr + 1'b1;
                            fl_addr_d = rd_addr + 1'b1;
                            state_d   = S_PREF;
                        end
                    end else begin
                        iss        = 1'b1;
                        iss_addr   = rd_addr;
                        fl_addr_d  = rd_addr;
                        dem_fill_d = fill_ok;
                        state_d    = S_DEMAND;
                    end
                end
            end
            S_DEMAND: begin
                if (arr_ready) begin
                    rv_d    = 1'b1;
                    rdat_d  = arr_data;
                    wr_en   = dem_fill_q && cfg_buf_en;
                    state_d = S_IDLE;
                end
            end
            S_PREF: begin
                if (arr_ready) begin
                    wr_en   = cfg_buf_en;
                    state_d = S_IDLE;
                end else if (accept) begin
                    if (lk_hit) begin
                        rv_d   = 1'b1;
                        rdat_d = lk_data;
                        touch  = 1'b1;
                    end else if (rd_addr == fl_addr_q) begin
                        state_d = S_JOIN;
                    end else begin
                        hold_addr_d = rd_addr;
                        hold_fill_d = fill_ok;
                        state_d     = S_HOLD;
                    end
                end
            end
            S_JOIN: begin
                if (arr_ready) begin
                    rv_d    = 1'b1;
                    rdat_d  = arr_data;
                    wr_en   = cfg_buf_en;
                    state_d = S_IDLE;
                end
            end
            S_HOLD: begin
                if (arr_ready) begin
                    wr_en      = cfg_buf_en;
                    iss        = 1'b1;
                    iss_addr   = hold_addr_q;
                    fl_addr_d  = hold_addr_q;
                    dem_fill_d = hold_fill_q;
                    state_d    = S_DEMAND;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_addr_q   <= '0;
            hold_addr_q <= '0;
            dem_fill_q  <= 1'b0;
            hold_fill_q <= 1'b0;
            rv_q        <= 1'b0;
            rdat_q      <= '0;
            areq_q      <= 1'b0;
            aaddr_q     <= '0;
        end else begin
            fl_addr_q   <= fl_addr_d;
            hold_addr_q <= hold_addr_d;
            dem_fill_q  <= dem_fill_d;
            hold_fill_q <= hold_fill_d;
            rv_q        <= rv_d;
            rdat_q      <= rdat_d;
            areq_q      <= iss;
            if (iss) aaddr_q <= iss_addr;
        end
    end

    // R1
    hit_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && lk_hit) |=> rd_valid);

    // R8
    no_hit_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !cfg_buf_en) |=> !rd_valid);

    // R12
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_req |=> !arr_req);

    // R6
    pf_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && accept && lk_hit &&
         !(rd_instr && cfg_ipf_en && cfg_pf_mode[1])) |=> !arr_req);

    // R10
    join_nodup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PREF && accept && !lk_hit && rd_addr == fl_addr_q) |=> !arr_req);
endmodule

// File: rtl/fpb_ctrl.sv
module fpb_ctrl #(
    parameter int AW   = 8,
    parameter int DW   = 32,
    parameter int NBUF = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_buf_en,
    input  logic          cfg_ipf_en,
    input  logic [1:0]    cfg_pf_mode,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    input  logic          rd_instr,
    output logic          rd_ready,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          arr_req,
    output logic [AW-1:0] arr_addr,
    input  logic          arr_ready,
    input  logic [DW-1:0] arr_data
);
    localparam int IW = $clog2(NBUF);

    logic          lk_hit, nx_hit, touch, wr_en;
    logic [IW-1:0] lk_idx;
    logic [DW-1:0] lk_data, wr_data;
    logic [AW-1:0] wr_addr, nx_addr;

    assign nx_addr = rd_addr + 1'b1;

    fpb_linebuf #(.NBUF(NBUF), .AW(AW), .DW(DW)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cfg_buf_en),
        .lk_addr (rd_addr),
        .lk_hit  (lk_hit),
        .lk_idx  (lk_idx),
        .lk_data (lk_data),
        .nx_addr (nx_addr),
        .nx_hit  (nx_hit),
        .touch   (touch),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    fpb_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_buf_en  (cfg_buf_en),
        .cfg_ipf_en  (cfg_ipf_en),
        .cfg_pf_mode (cfg_pf_mode),
        .rd_req      (rd_req),
        .rd_addr     (rd_addr),
        .rd_instr    (rd_instr),
        .rd_ready    (rd_ready),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .lk_hit      (lk_hit),
        .lk_data     (lk_data),
        .nx_hit      (nx_hit),
        .touch       (touch),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .arr_req     (arr_req),
        .arr_addr    (arr_addr),
        .arr_ready   (arr_ready),
        .arr_data    (arr_data)
    );
endmodule

// File: tb/fpb_ctrl_test.sv
module fpb_ctrl_test;
    localparam int LAT = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_buf_en = 1'b1, cfg_ipf_en = 1'b1;
    logic [1:0]  cfg_pf_mode = 2'b10;
    logic        rd_req = 1'b0, rd_instr = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic        rd_ready, rd_valid, arr_req;
    logic [31:0] rd_data;
    logic [7:0]  arr_addr;
    logic        arr_ready = 1'b0;
    logic [31:0] arr_data = '0;

    int total = 0, bad = 0, arr_cnt = 0, overlap = 0, cyc = 0;
    logic        m_busy = 1'b0, prev_req = 1'b0;
    int          m_cnt = 0;
    logic [7:0]  m_addr = '0;

    fpb_ctrl uut (.*);

    always #10 clk = ~clk;

    function automatic logic [31:0] line_of(input logic [7:0] a);
        return {~a, a, a ^ 8'h5A, 8'hC3};
    endfunction

    // array model: fixed latency, one outstanding request
    always @(posedge clk) begin
        arr_ready <= 1'b0;
        if (arr_req) begin
            if (m_busy || prev_req) overlap++;
            arr_cnt++;
            m_busy <= 1'b1;
            m_cnt  <= LAT - 1;
            m_addr <= arr_addr;
        end else if (m_busy) begin
            if (m_cnt == 0) begin
                arr_ready <= 1'b1;
                arr_data  <= line_of(m_addr);
                m_busy    <= 1'b0;
            end else begin
                m_cnt <= m_cnt - 1;
            end
        end
        prev_req <= arr_req;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_read(input logic instr, input logic [7:0] a,
                           output int lat, output logic [31:0] d);
        @(negedge clk);
        while (!rd_ready) @(negedge clk);
        rd_req = 1'b1; rd_addr = a; rd_instr = instr;
        @(negedge clk);
        rd_req = 1'b0;
        lat = 1;
        while (!rd_valid && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        d = rd_data;
    endtask

    task automatic quiet();
        repeat (20) @(negedge clk);
    endtask

    // {req[18:15], instr[14], addr[13:6], mode[5:4], ipf[3], hit[2], narr[1:0]}
    localparam int NV = 22;
    localparam logic [18:0] VEC [NV] = '{
        {4'd2, 1'b1, 8'h10, 2'b10, 1'b1, 1'b0, 2'd1},  // R2 first instruction miss
        {4'd5, 1'b1, 8'h10, 2'b10, 1'b1, 1'b1, 2'd1},  // R5 hit prefetches 0x11
        {4'd5, 1'b1, 8'h11, 2'b10, 1'b1, 1'b1, 2'd1},  // R5 prefetched line hits, fetches 0x12
        {4'd6, 1'b0, 8'h20, 2'b10, 1'b1, 1'b0, 2'd1},  // R6 data miss
        {4'd1, 1'b0, 8'h20, 2'b10, 1'b1, 1'b1, 2'd0},  // R1 data hit, no access
        {4'd5, 1'b1, 8'h12, 2'b10, 1'b1, 1'b1, 2'd1},  // R5 hit fetches 0x13
        {4'd9, 1'b1, 8'h10, 2'b10, 1'b1, 1'b0, 2'd1},  // R9 0x10 was least recent
        {4'd5, 1'b1, 8'h12, 2'b10, 1'b1, 1'b1, 2'd0},  // R5 next line held, no prefetch
        {4'd9, 1'b1, 8'h11, 2'b10, 1'b1, 1'b0, 2'd1},  // R9 0x11 replaced by 0x10 fill
        {4'd4, 1'b1, 8'h40, 2'b01, 1'b1, 1'b0, 2'd1},  // R4 miss kept
        {4'd4, 1'b1, 8'h40, 2'b01, 1'b1, 1'b1, 2'd0},  // R4 hit, no prefetch
        {4'd3, 1'b1, 8'h50, 2'b00, 1'b1, 1'b0, 2'd1},  // R3 miss
        {4'd3, 1'b1, 8'h50, 2'b00, 1'b1, 1'b0, 2'd1},  // R3 not kept
        {4'd6, 1'b0, 8'h60, 2'b00, 1'b1, 1'b0, 2'd1},  // R6 data kept in mode 00
        {4'd6, 1'b0, 8'h60, 2'b00, 1'b1, 1'b1, 2'd0},  // R6
        {4'd7, 1'b1, 8'h70, 2'b10, 1'b0, 1'b0, 2'd1},  // R7 miss
        {4'd7, 1'b1, 8'h70, 2'b10, 1'b0, 1'b0, 2'd1},  // R7 not kept
        {4'd7, 1'b1, 8'h60, 2'b10, 1'b0, 1'b1, 2'd0},  // R7 hit, no prefetch
        {4'd6, 1'b0, 8'h60, 2'b10, 1'b1, 1'b1, 2'd0},  // R6 data hit never prefetches
        {4'd5, 1'b1, 8'hFF, 2'b10, 1'b1, 1'b0, 2'd1},  // R5 miss, no next-line fetch
        {4'd5, 1'b1, 8'hFF, 2'b10, 1'b1, 1'b1, 2'd1},  // R5 hit prefetches wrapped 0x00
        {4'd5, 1'b1, 8'h00, 2'b10, 1'b1, 1'b1, 2'd1}   // R5 wrapped line held
    };

    initial begin
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        chk(1'b0, "watchdog", cyc, 100000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lat, base;
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_ready === 1'b1, "reset rd_ready", rd_ready, 1);
        chk(rd_valid === 1'b0, "reset rd_valid", rd_valid, 0);
        chk(arr_req === 1'b0, "reset arr_req", arr_req, 0);

        for (int i = 0; i < NV; i++) begin
            logic [18:0] v;
            v = VEC[i];
            cfg_pf_mode = v[5:4];
            cfg_ipf_en  = v[3];
            base = arr_cnt;
            do_read(v[14], v[13:6], lat, d);
            quiet();
            chk(d == line_of(v[13:6]), $sformatf("R%0d vec%0d data", v[18:15], i), d, line_of(v[13:6]));
            if (v[2]) chk(lat == 1, $sformatf("R%0d vec%0d hit latency", v[18:15], i), lat, 1);
            else      chk(lat > 1,  $sformatf("R%0d vec%0d miss latency", v[18:15], i), lat, 2);
            chk(arr_cnt - base == int'(v[1:0]), $sformatf("R%0d vec%0d array accesses", v[18:15], i),
                arr_cnt - base, v[1:0]);
        end

        // R8: buffers disabled, a held line misses and starts nothing else
        cfg_pf_mode = 2'b10; cfg_ipf_en = 1'b1; cfg_buf_en = 1'b0;
        base = arr_cnt;
        do_read(1'b1, 8'h00, lat, d);
        quiet();
        chk(lat > 1, "R8 disabled read misses", lat, 2);
        chk(arr_cnt - base == 1, "R8 disabled one access", arr_cnt - base, 1);
        cfg_buf_en = 1'b1;
        base = arr_cnt;
        do_read(1'b0, 8'h60, lat, d);
        quiet();
        chk(lat > 1, "R8 invalidated line misses", lat, 2);
        chk(arr_cnt - base == 1, "R8 refetch", arr_cnt - base, 1);

        // R10: same-line miss joins the prefetch
        do_read(1'b1, 8'h80, lat, d);
        quiet();
        base = arr_cnt;
        do_read(1'b1, 8'h80, lat, d);
        do_read(1'b1, 8'h81, lat, d);
        quiet();
        chk(d == line_of(8'h81), "R10 join data", d, line_of(8'h81));
        chk(lat > 1, "R10 join waits", lat, 2);
        chk(arr_cnt - base == 1, "R10 no duplicate access", arr_cnt - base, 1);

        // R10: hit served during prefetch
        do_read(1'b1, 8'hB0, lat, d);
        quiet();
        base = arr_cnt;
        do_read(1'b1, 8'hB0, lat, d);
        do_read(1'b1, 8'hB0, lat, d);
        chk(lat == 1, "R10 hit during prefetch", lat, 1);
        quiet();
        chk(arr_cnt - base == 1, "R10 single prefetch", arr_cnt - base, 1);

        // R11: other-line miss waits for the prefetch
        do_read(1'b1, 8'h90, lat, d);
        quiet();
        base = arr_cnt;
        do_read(1'b1, 8'h90, lat, d);
        do_read(1'b0, 8'hA0, lat, d);
        quiet();
        chk(d == line_of(8'hA0), "R11 held miss data", d, line_of(8'hA0));
        chk(lat > LAT, "R11 held miss waits", lat, LAT + 1);
        chk(arr_cnt - base == 2, "R11 accesses", arr_cnt - base, 2);
        do_read(1'b0, 8'hA0, lat, d);
        chk(lat == 1, "R11 held line kept", lat, 1);
        quiet();

        chk(overlap == 0, "R12 overlapping requests", overlap, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule